// File: doc/BRIEF.md
# Eight-Bit GPIO Port with SPI Pin Direction Override

This block is an eight-pin general-purpose I/O port. Software writes a direction register and a data register through a small register interface. Each pad gets an output enable, a drive value and a pull-up enable. A pin whose direction bit is set drives its data bit push-pull. A pin whose direction bit is clear is an input, and its data bit then turns on the weak pull-up. Pad input levels pass through a two-stage synchronizer, and the second stage is the value returned from the pin-read address.

Four pins can serve a serial peripheral interface: serial clock, master-in, master-out and slave select. When the SPI is enabled, its mode forces some of these pins to be inputs, whatever their direction bits say. Pull-up control of a forced pin stays with its data bit. In slave mode the block also reports, active high, that the SPI is selected. It takes this from the synchronized level of the select pin. The serial shift logic itself sits outside this block.

Top module: `gpio_spi_port`

## Requirements
- R1: While `rst` is high, every pad is released (`pad_oe`, `pad_pu` and `pad_out` all zero) at once, without waiting for a clock edge. After the reset clock edge, the direction and data registers read zero.
- R2: With no SPI override on a pin, a direction bit of 1 sets that pin's `pad_oe` and drives the data bit on `pad_out`.
- R3: `pad_pu` of a pin is 1 only when that pin is not driven and its data bit is 1. `pad_out` is 0 whenever `pad_oe` is 0.
- R4: With `spi_en`=1 and `spi_master`=0 (slave), pins 7, 5 and 4 are never driven, whatever their direction bits. Each of them has its pull-up set to its data bit.
- R5: With `spi_en`=1 and `spi_master`=1, pin 6 is never driven and has its pull-up set to its data bit. Pins 7, 5 and 4 follow their direction bits.
- R6: In slave mode, pin 6 follows its direction bit.
- R7: With `spi_en`=0, all eight pins follow only the direction and data registers, whatever the value of `spi_master`.
- R8: The pin-read address (`addr`=2) returns `pad_in` as it stood before the second rising clock edge. A change in `pad_in` does not appear after only one edge.
- R9: `spi_slave_sel` is 1 exactly when `spi_en`=1, `spi_master`=0 and the synchronized level of pin 4 is 0.
- R10: Writes to address 2 (pin read) and address 3 (unused) change no register. Address 3 reads as zero.
- R11: A write with `wr_en`=1 to address 0 loads the data register, and a write to address 1 loads the direction register. Both read back at the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also releases pads at once |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select: 0 data, 1 direction, 2 pin read, 3 unused |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read of the register at `addr` |
| spi_en | input | 1 | SPI alternate function enabled |
| spi_master | input | 1 | SPI is master (1) or slave (0) |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad drive values |
| pad_pu | output | 8 | Pad pull-up enables |
| spi_slave_sel | output | 1 | SPI slave selected (active high) |

## Verification
The assertions check, on every cycle, the rules that must hold at any moment. Pads are released during reset, and a pin is never driven and pulled up at the same time. Pins forced by the SPI mode are never driven. With the SPI off, the enables match the direction register, and the select flag is raised only in slave mode. Some behaviour shows only across a sequence of cycles, so only the bench scenarios can show it. This covers the exact two-edge latency of the pin-read path, register readback, and writes to the read-only and unused addresses being ignored. It also covers the exact pull-up and drive values for chosen register patterns in each SPI mode.

// File: rtl/gpio_spi_pkg.sv
`timescale 1ns/1ps
package gpio_spi_pkg;

    localparam int unsigned PORT_W = 8;
    localparam int unsigned ADDR_W = 2;

    // Alternate-function pin positions (behaviour depends on these)
    localparam int unsigned PIN_SCLK = 7;
    localparam int unsigned PIN_MIN  = 6;
    localparam int unsigned PIN_MOUT = 5;
    localparam int unsigned PIN_SEL  = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_PINS = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic drv;
        logic pu;
    } pad_ctl_t;

    // Pins that the SPI mode forces to be inputs
    function automatic logic [PORT_W-1:0] force_in_mask(input logic en, input logic master);
        logic [PORT_W-1:0] m;
        m = '0;
        if (en) begin
            if (master) begin
                m[PIN_MIN] = 1'b1;
            end else begin
                m[PIN_SCLK] = 1'b1;
                m[PIN_MOUT] = 1'b1;
                m[PIN_SEL]  = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_spi_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  reg_sel_e     wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                REG_DATA: data_q <= wr_data;
                REG_DIR:  dir_q  <= wr_data;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pins_q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= pad_in;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign pins_q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctrl.sv
`timescale 1ns/1ps
module gpio_pin_ctrl
    import gpio_spi_pkg::*;
#(
    parameter int unsigned W = PORT_W
) (
    input  logic         rst,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] force_in,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);

    for (genvar g = 0; g < int'(W); g++) begin : g_pin
        pad_ctl_t ctl;
        always_comb begin
            ctl.oe  = dir_q[g] & ~force_in[g] & ~rst;
            ctl.drv = ctl.oe & data_q[g];
            ctl.pu  = ~ctl.oe & data_q[g] & ~rst;
        end
        assign pad_oe[g]  = ctl.oe;
        assign pad_out[g] = ctl.drv;
        assign pad_pu[g]  = ctl.pu;
    end

endmodule

// File: rtl/gpio_spi_port.sv
`timescale 1ns/1ps
module gpio_spi_port
    import gpio_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic              spi_en,
    input  logic              spi_master,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu,
    output logic              spi_slave_sel
);

    reg_sel_e          sel;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] data_q;
    logic [PORT_W-1:0] pins_q;
    logic [PORT_W-1:0] force_in;

    assign sel      = reg_sel_e'(addr);
    assign force_in = force_in_mask(spi_en, spi_master);

    gpio_regs #(.W(PORT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .data_q  (data_q)
    );

    gpio_in_sync #(.W(PORT_W), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .pins_q (pins_q)
    );

    gpio_pin_ctrl #(.W(PORT_W)) u_ctrl (
        .rst      (rst),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .force_in (force_in),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pad_pu   (pad_pu)
    );

    always_comb begin
        case (sel)
            REG_DATA: rd_data = data_q;
            REG_DIR:  rd_data = dir_q;
            REG_PINS: rd_data = pins_q;
            default:  rd_data = '0;
        endcase
    end

    assign spi_slave_sel = spi_en & ~spi_master & ~pins_q[PIN_SEL];

endmodule

// File: rtl/gpio_spi_port_chk.sv
`timescale 1ns/1ps
module gpio_spi_port_chk
    import gpio_spi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              spi_en,
    input logic              spi_master,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_out,
    input logic [PORT_W-1:0] pad_pu,
    input logic              spi_slave_sel,
    input logic [PORT_W-1:0] dir_q
);

    // R1: pads released whenever reset is sampled high
    always @(posedge clk) begin
        if (rst) begin
            p_pads_released_r1: assert (pad_oe == '0 && pad_pu == '0 && pad_out == '0)
                else $error("pads active during reset");
        end
    end

    // R3: never driven and pulled up at once
    p_no_drive_with_pull_r3: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_pu) == '0);

    // R3: undriven pins present zero drive value
    p_quiet_when_released_r3: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0);

    // R4: slave mode never drives clock, master-out, select pins
    p_slave_forced_in_r4: assert property (@(posedge clk) disable iff (rst)
        (spi_en && !spi_master) |-> (!pad_oe[PIN_SCLK] && !pad_oe[PIN_MOUT] && !pad_oe[PIN_SEL]));

    // R5: master mode never drives master-in pin
    p_master_forced_in_r5: assert property (@(posedge clk) disable iff (rst)
        (spi_en && spi_master) |-> !pad_oe[PIN_MIN]);

    // R7: SPI off means enables equal the direction register
    p_plain_port_r7: assert property (@(posedge clk) disable iff (rst)
        !spi_en |-> (pad_oe == dir_q));

    // R9: select flag only in slave mode
    p_sel_only_slave_r9: assert property (@(posedge clk) disable iff (rst)
        spi_slave_sel |-> (spi_en && !spi_master));

endmodule

bind gpio_spi_port gpio_spi_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .spi_en        (spi_en),
    .spi_master    (spi_master),
    .pad_oe        (pad_oe),
    .pad_out       (pad_out),
    .pad_pu        (pad_pu),
    .spi_slave_sel (spi_slave_sel),
    .dir_q         (dir_q)
);

// File: tb/gpio_spi_port_bench.sv
`timescale 1ns/1ps
module gpio_spi_port_bench;

    typedef enum int {K_OE, K_OUT, K_PU, K_RD, K_SS} kind_e;
    typedef struct {
        string      tag;
        kind_e      kind;
        logic [7:0] val;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       spi_en = 1'b0;
    logic       spi_master = 1'b0;
    logic [7:0] pad_in = 8'hFF;
    logic [7:0] pad_oe, pad_out, pad_pu;
    logic       spi_slave_sel;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    gpio_spi_port u_gpio_spi_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .spi_en(spi_en), .spi_master(spi_master),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .spi_slave_sel(spi_slave_sel)
    );

    task automatic push(input string tag, input kind_e k, input logic [7:0] v);
        exp_t e;
        e.tag = tag; e.kind = k; e.val = v;
        q.push_back(e);
    endtask

    // Expected pad controls from the requirements
    task automatic expect_pads(input string tag, input logic [7:0] dir, input logic [7:0] data,
                               input logic en, input logic master);
        logic [7:0] forced, oe;
        forced = en ? (master ? 8'h40 : 8'hB0) : 8'h00;
        oe = dir & ~forced;
        push(tag, K_OE, oe);
        push(tag, K_OUT, oe & data);
        push(tag, K_PU, ~oe & data);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                logic [7:0] act;
                e = q.pop_front();
                case (e.kind)
                    K_OE:    act = pad_oe;
                    K_OUT:   act = pad_out;
                    K_PU:    act = pad_pu;
                    K_RD:    act = rd_data;
                    default: act = {7'd0, spi_slave_sel};
                endcase
                checks++;
                if (act !== e.val) begin
                    errors++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", e.tag, e.kind, act, e.val);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: pads released during reset
        @(negedge clk); @(negedge clk);
        expect_pads("R1 in reset", 8'h00, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        addr = 2'd1; push("R1 dir after reset", K_RD, 8'h00);
        @(negedge clk);
        addr = 2'd0; push("R1 data after reset", K_RD, 8'h00);

        // R2 R3 R7 R11: plain port
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h0F);
        spi_master = 1'b1;  // ignored while SPI is off
        expect_pads("R2 R3 R7 plain", 8'h0F, 8'hA5, 1'b0, 1'b1);
        addr = 2'd0; push("R11 data readback", K_RD, 8'hA5);
        @(negedge clk);
        addr = 2'd1; push("R11 dir readback", K_RD, 8'h0F);

        // R4 R6: slave mode, all directions out
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'h30);
        spi_en = 1'b1; spi_master = 1'b0;
        expect_pads("R4 R6 slave", 8'hFF, 8'h30, 1'b1, 1'b0);
        @(negedge clk);
        wr(2'd0, 8'hC3);
        expect_pads("R4 R6 slave alt data", 8'hFF, 8'hC3, 1'b1, 1'b0);

        // R5: master mode
        @(negedge clk);
        spi_master = 1'b1;
        wr(2'd0, 8'h40);
        expect_pads("R5 master", 8'hFF, 8'h40, 1'b1, 1'b1);
        @(negedge clk);
        wr(2'd1, 8'h4A);
        wr(2'd0, 8'hF0);
        expect_pads("R5 master mixed dir", 8'h4A, 8'hF0, 1'b1, 1'b1);

        // R8: two-edge pin-read latency
        @(negedge clk);
        addr = 2'd2;
        pad_in = 8'h3C;
        push("R8 before edge", K_RD, 8'hFF);
        @(negedge clk);
        push("R8 after one edge", K_RD, 8'hFF);
        @(negedge clk);
        push("R8 after two edges", K_RD, 8'h3C);

        // R9: slave select
        @(negedge clk);
        spi_master = 1'b0;
        push("R9 select high pin", K_SS, 8'h00);
        pad_in = 8'h2C;
        @(negedge clk);
        push("R9 one edge", K_SS, 8'h00);
        @(negedge clk);
        push("R9 selected", K_SS, 8'h01);
        @(negedge clk);
        spi_master = 1'b1;
        push("R9 master no select", K_SS, 8'h00);
        @(negedge clk);
        spi_en = 1'b0; spi_master = 1'b0;
        push("R9 disabled no select", K_SS, 8'h00);

        // R10: writes to pin-read and unused addresses ignored
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        addr = 2'd1; push("R10 dir kept", K_RD, 8'h4A);
        @(negedge clk);
        addr = 2'd0; push("R10 data kept", K_RD, 8'hF0);
        @(negedge clk);
        addr = 2'd3; push("R10 unused reads zero", K_RD, 8'h00);
        @(negedge clk);
        expect_pads("R10 R7 pads unchanged", 8'h4A, 8'hF0, 1'b0, 1'b0);

        // R1: reset mid-run releases pads before any clock edge
        wr(2'd1, 8'hFF);
        rst = 1'b1;
        expect_pads("R1 immediate release", 8'h00, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        addr = 2'd1; push("R1 dir cleared", K_RD, 8'h00);

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule